// File: doc/BRIEF.md
# Carrier Phase Lock Supervisor

This block decides whether the carrier recovery loop of a satellite PSK receiver has reached phase lock, and steers the loop while it has not. Each received complex symbol is turned into a non-data-aided lock metric: the real part of the symbol raised to the second power for two-phase signals, or to the fourth power for four-phase signals. The metric is smoothed by a first-order low-pass filter. A three-state controller uses the smoothed value to move between searching, locked and frequency-sweep states.

A mode input picks one of two behaviours. In framed mode the incoming symbols are two-phase header and burst symbols. The metric is only taken while the frame-lock input is high, and lock must hold over two frame strobes. In continuous mode the symbols are four-phase, and the qualification spans a programmable number of symbols. If no lock is found within a programmable number of cycles, the controller enters a sweep state. In that state it emits a sawtooth offset, which is added to the external frequency estimate. The block also drives a two-level loop-filter gain selection and an enable for the frequency estimator. It raises a flag that points to multipath when lock is still missing after a programmable number of frames or symbols.

Top module: `phsync_ctrl`

## Requirements
- R1: On every metric-valid cycle the filtered metric becomes f + ((m - f) >>> K), with K = 2 by default. The metric m is I*I - Q*Q in framed mode (cs_mode = 0) and (I*I - Q*Q)^2 - (2*I*Q)^2 in continuous mode (cs_mode = 1). A metric-valid cycle is sym_vld high, and in framed mode frame_sync high as well.
- R2: In framed mode, symbols that arrive while frame_sync is low leave the filtered metric unchanged.
- R3: After reset the state code is 0 (searching), the filtered metric is 0, lf_acq is 1, fest_en is 1, sweep_o is 0 and mp_flag is 0. The state code is never 3.
- R4: In framed mode the state goes from 0 to 1 (locked) on the frame strobe that is the second one counted while the filtered metric stays above th1. If the metric falls to th1 or below, the count restarts.
- R5: In continuous mode the same qualification counts symbols, and the state goes to 1 on the qual_syms-th symbol counted without interruption.
- R6: In the locked state, a filtered metric below zero returns the state to 0 on the next cycle.
- R7: After tmo_lim + 1 cycles in state 0 without qualifying, the state goes to 2 (sweep) and chirp_on is high for as long as the block stays there.
- R8: In state 2, a filtered metric above th1 moves the state to 1 on the next cycle, with no qualification count.
- R9: In state 2, sweep_o rises by sweep_step each cycle and reloads sweep_lo when the sum would exceed sweep_hi. Outside state 2 it reloads sweep_lo. fsum_o always equals fest_i + sweep_o.
- R10: lf_acq goes to 1 on the cycle after the filtered metric is above th1. It goes to 0 on the cycle after the metric is below th2 and not above th1. Otherwise it holds.
- R11: fest_en is low exactly while the state is 1.
- R12: While not locked, the block counts events from the moment the sync source rises. In framed mode it counts frame strobes under frame_sync; in continuous mode it counts symbols under timing_sync. mp_flag is high while that count equals mp_lim. Lock or loss of the sync source clears both the count and the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_mode | input | 1 | 0 framed two-phase mode, 1 continuous four-phase mode |
| sym_vld | input | 1 | Symbol present on sym_i/sym_q |
| sym_i | input | W | In-phase sample, signed |
| sym_q | input | W | Quadrature sample, signed |
| frame_sync | input | 1 | Frame lock established |
| frame_stb | input | 1 | One pulse per received frame |
| timing_sync | input | 1 | Symbol timing lock established |
| th1 | input | MW | Upper threshold, signed |
| th2 | input | MW | Lower threshold, signed |
| qual_syms | input | CW | Continuous-mode qualification length in symbols |
| tmo_lim | input | CW | Search timeout in cycles, minus one |
| mp_lim | input | CW | Multipath event count |
| sweep_step | input | SW | Sawtooth increment, signed, positive |
| sweep_lo | input | SW | Sawtooth reload value, signed |
| sweep_hi | input | SW | Sawtooth upper bound, signed |
| fest_i | input | SW | Frequency offset estimate, signed |
| state_o | output | 2 | 0 searching, 1 locked, 2 sweep |
| chirp_on | output | 1 | Sweep state active |
| fest_en | output | 1 | Frequency estimator enable |
| lf_acq | output | 1 | Loop filter wide-gain selection |
| sweep_o | output | SW | Sawtooth value |
| fsum_o | output | SW+1 | Estimate plus sawtooth |
| mp_flag | output | 1 | Multipath suspected |
| filt_o | output | MW | Filtered lock metric |

## Verification
On every cycle the assertions check several local rules: filter hold while frame lock is absent, exit from lock on a negative metric, the direct jump from sweep to lock, both edges of the gain selection, the sawtooth reload outside the sweep state, and clearing of the multipath flag once locked. Other behaviours depend on histories that span many cycles. These are the two-strobe and symbol-count qualification with its restart after a dip, the timeout length, the sawtooth wrap point, and the multipath count. Only the bench's scenarios can show them, with a behavioural model compared against the outputs on each clock.

// File: rtl/phsync_pkg.sv
package phsync_pkg;
    typedef enum logic [1:0] {
        PS_SEARCH = 2'd0,
        PS_LOCK   = 2'd1,
        PS_SWEEP  = 2'd2
    } ps_state_e;
endpackage

// File: rtl/phsync_metric.sv
module phsync_metric #(
    parameter int W  = 6,
    localparam int MW = 4*W+3
) (
    input  logic signed [W-1:0]  sym_i,
    input  logic signed [W-1:0]  sym_q,
    input  logic                 cs_mode,
    output logic signed [MW-1:0] metric
);
    logic signed [2*W-1:0] ie, qe, ii, qq, iq;
    logic signed [2*W:0]   re2, im2;
    logic signed [MW-1:0]  r2x, i2x, re4;

    always_comb begin
        ie  = $signed({{W{sym_i[W-1]}}, sym_i});
        qe  = $signed({{W{sym_q[W-1]}}, sym_q});
        ii  = ie * ie;
        qq  = qe * qe;
        iq  = ie * qe;
        re2 = $signed({ii[2*W-1], ii}) - $signed({qq[2*W-1], qq});
        im2 = $signed({iq, 1'b0});
        r2x = $signed({{(MW-2*W-1){re2[2*W]}}, re2});
        i2x = $signed({{(MW-2*W-1){im2[2*W]}}, im2});
        re4 = r2x * r2x - i2x * i2x;
        metric = cs_mode ? re4 : r2x;
    end
endmodule

// File: rtl/phsync_lpf.sv
module phsync_lpf #(
    parameter int MW = 27,
    parameter int K  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 vld,
    input  logic signed [MW-1:0] metric,
    output logic signed [MW-1:0] filt
);
    logic signed [MW:0]   diff_w, step_w, sum_w;
    logic signed [MW-1:0] filt_d, filt_q;

    always_comb begin
        diff_w = $signed({metric[MW-1], metric}) - $signed({filt_q[MW-1], filt_q});
        step_w = diff_w >>> K;
        sum_w  = $signed({filt_q[MW-1], filt_q}) + step_w;
        filt_d = vld ? $signed(sum_w[MW-1:0]) : filt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) filt_q <= '0;
        else        filt_q <= filt_d;
    end

    assign filt = filt_q;
endmodule

// File: rtl/phsync_sweep.sv
module phsync_sweep #(
    parameter int SW = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run,
    input  logic signed [SW-1:0] step,
    input  logic signed [SW-1:0] lo,
    input  logic signed [SW-1:0] hi,
    output logic signed [SW-1:0] sweep
);
    logic signed [SW:0]   nxt_w, hi_w;
    logic signed [SW-1:0] saw_d, saw_q;

    always_comb begin
        nxt_w = $signed({saw_q[SW-1], saw_q}) + $signed({step[SW-1], step});
        hi_w  = $signed({hi[SW-1], hi});
        if (!run)             saw_d = lo;
        else if (nxt_w > hi_w) saw_d = lo;
        else                  saw_d = $signed(nxt_w[SW-1:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) saw_q <= '0;
        else        saw_q <= saw_d;
    end

    assign sweep = saw_q;
endmodule

// File: rtl/phsync_ctrl.sv
module phsync_ctrl
    import phsync_pkg::*;
#(
    parameter int W  = 6,
    parameter int K  = 2,
    parameter int CW = 16,
    parameter int SW = 12,
    localparam int MW = 4*W+3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_mode,
    input  logic                 sym_vld,
    input  logic signed [W-1:0]  sym_i,
    input  logic signed [W-1:0]  sym_q,
    input  logic                 frame_sync,
    input  logic                 frame_stb,
    input  logic                 timing_sync,
    input  logic signed [MW-1:0] th1,
    input  logic signed [MW-1:0] th2,
    input  logic [CW-1:0]        qual_syms,
    input  logic [CW-1:0]        tmo_lim,
    input  logic [CW-1:0]        mp_lim,
    input  logic signed [SW-1:0] sweep_step,
    input  logic signed [SW-1:0] sweep_lo,
    input  logic signed [SW-1:0] sweep_hi,
    input  logic signed [SW-1:0] fest_i,
    output logic [1:0]           state_o,
    output logic                 chirp_on,
    output logic                 fest_en,
    output logic                 lf_acq,
    output logic signed [SW-1:0] sweep_o,
    output logic signed [SW:0]   fsum_o,
    output logic                 mp_flag,
    output logic signed [MW-1:0] filt_o
);
    typedef struct packed {
        ps_state_e   st;
        logic [CW-1:0] qcnt;
        logic [CW-1:0] tmr;
        logic [CW-1:0] mpcnt;
        logic        mpflag;
        logic        lfacq;
    } ctl_t;

    ctl_t c_d, c_q;

    logic signed [MW-1:0] met_w, filt_w;
    logic met_vld, above, neg, below2, qev, mev, msrc;
    logic [CW:0] qinc, qtgt;

    assign met_vld = sym_vld & (cs_mode | frame_sync);

    phsync_metric #(.W(W)) u_metric (
        .sym_i   (sym_i),
        .sym_q   (sym_q),
        .cs_mode (cs_mode),
        .metric  (met_w)
    );

    phsync_lpf #(.MW(MW), .K(K)) u_lpf (
        .clk    (clk),
        .rst_n  (rst_n),
        .vld    (met_vld),
        .metric (met_w),
        .filt   (filt_w)
    );

    always_comb begin
        above  = filt_w > th1;
        neg    = filt_w[MW-1];
        below2 = filt_w < th2;
        qev    = cs_mode ? sym_vld : frame_stb;
        msrc   = cs_mode ? timing_sync : frame_sync;
        mev    = msrc & (cs_mode ? sym_vld : frame_stb);
        qinc   = {1'b0, c_q.qcnt} + (CW+1)'(1);
        qtgt   = cs_mode ? {1'b0, qual_syms} : (CW+1)'(2);

        c_d = c_q;

        // lock state machine
        unique case (c_q.st)
            PS_SEARCH: begin
                if (!above)   c_d.qcnt = '0;
                else if (qev) c_d.qcnt = qinc[CW-1:0];
                if (above && qev && (qinc >= qtgt)) begin
                    c_d.st   = PS_LOCK;
                    c_d.qcnt = '0;
                    c_d.tmr  = '0;
                end else if (c_q.tmr == tmo_lim) begin
                    c_d.st   = PS_SWEEP;
                    c_d.qcnt = '0;
                    c_d.tmr  = '0;
                end else begin
                    c_d.tmr  = c_q.tmr + CW'(1);
                end
            end
            PS_SWEEP: begin
                c_d.qcnt = '0;
                c_d.tmr  = '0;
                if (above) c_d.st = PS_LOCK;
            end
            default: begin
                c_d.qcnt = '0;
                c_d.tmr  = '0;
                if (neg) c_d.st = PS_SEARCH;
            end
        endcase

        // loop-filter gain selection
        if (above)       c_d.lfacq = 1'b1;
        else if (below2) c_d.lfacq = 1'b0;

        // multipath suspicion counter
        if (c_q.st == PS_LOCK || !msrc) begin
            c_d.mpcnt  = '0;
            c_d.mpflag = 1'b0;
        end else begin
            if (mev && c_q.mpcnt != mp_lim) c_d.mpcnt = c_q.mpcnt + CW'(1);
            c_d.mpflag = (c_d.mpcnt == mp_lim);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.st     <= PS_SEARCH;
            c_q.qcnt   <= '0;
            c_q.tmr    <= '0;
            c_q.mpcnt  <= '0;
            c_q.mpflag <= 1'b0;
            c_q.lfacq  <= 1'b1;
        end else begin
            c_q <= c_d;
        end
    end

    phsync_sweep #(.SW(SW)) u_sweep (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (c_q.st == PS_SWEEP),
        .step  (sweep_step),
        .lo    (sweep_lo),
        .hi    (sweep_hi),
        .sweep (sweep_o)
    );

    assign state_o  = c_q.st;
    assign chirp_on = (c_q.st == PS_SWEEP);
    assign fest_en  = (c_q.st != PS_LOCK);
    assign lf_acq   = c_q.lfacq;
    assign mp_flag  = c_q.mpflag;
    assign filt_o   = filt_w;
    assign fsum_o   = $signed({fest_i[SW-1], fest_i}) + $signed({sweep_o[SW-1], sweep_o});
endmodule

// File: rtl/phsync_ctrl_chk.sv
module phsync_ctrl_chk #(
    parameter int MW = 27,
    parameter int SW = 12
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cs_mode,
    input logic                 frame_sync,
    input logic signed [MW-1:0] th1,
    input logic signed [MW-1:0] th2,
    input logic signed [SW-1:0] sweep_lo,
    input logic [1:0]           state_o,
    input logic                 lf_acq,
    input logic signed [SW-1:0] sweep_o,
    input logic                 mp_flag,
    input logic signed [MW-1:0] filt_o
);
    assert_hold_nosync_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_mode && !frame_sync) |=> (filt_o == $past(filt_o)));

    assert_state_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        state_o != 2'd3);

    assert_lock_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd1 && filt_o < 0) |=> (state_o == 2'd0));

    assert_sweep_to_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd2 && filt_o > th1) |=> (state_o == 2'd1));

    assert_saw_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o != 2'd2) |=> (sweep_o == $past(sweep_lo)));

    assert_gain_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_o > th1) |=> lf_acq);

    assert_gain_clr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!(filt_o > th1) && filt_o < th2) |=> !lf_acq);

    assert_mp_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd1) |=> !mp_flag);
endmodule

bind phsync_ctrl phsync_ctrl_chk #(.MW(MW), .SW(SW)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_mode    (cs_mode),
    .frame_sync (frame_sync),
    .th1        (th1),
    .th2        (th2),
    .sweep_lo   (sweep_lo),
    .state_o    (state_o),
    .lf_acq     (lf_acq),
    .sweep_o    (sweep_o),
    .mp_flag    (mp_flag),
    .filt_o     (filt_o)
);

// File: tb/phsync_ctrl_tb.sv
module phsync_ctrl_tb_top;
    localparam int W  = 6;
    localparam int K  = 2;
    localparam int CW = 16;
    localparam int SW = 12;
    localparam int MW = 4*W+3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_mode = 1'b0, sym_vld = 1'b0, frame_sync = 1'b0, frame_stb = 1'b0, timing_sync = 1'b0;
    logic signed [W-1:0]  sym_i = '0, sym_q = '0;
    logic signed [MW-1:0] th1 = 200, th2 = 100;
    logic [CW-1:0]        qual_syms = 5, tmo_lim = 1000, mp_lim = 1000;
    logic signed [SW-1:0] sweep_step = 30, sweep_lo = -50, sweep_hi = 50, fest_i = 100;
    logic [1:0]           state_o;
    logic                 chirp_on, fest_en, lf_acq, mp_flag;
    logic signed [SW-1:0] sweep_o;
    logic signed [SW:0]   fsum_o;
    logic signed [MW-1:0] filt_o;

    int nchk = 0;
    int nerr = 0;

    always #10 clk = ~clk;

    phsync_ctrl #(.W(W), .K(K), .CW(CW), .SW(SW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_mode(cs_mode), .sym_vld(sym_vld),
        .sym_i(sym_i), .sym_q(sym_q), .frame_sync(frame_sync), .frame_stb(frame_stb),
        .timing_sync(timing_sync), .th1(th1), .th2(th2), .qual_syms(qual_syms),
        .tmo_lim(tmo_lim), .mp_lim(mp_lim), .sweep_step(sweep_step), .sweep_lo(sweep_lo),
        .sweep_hi(sweep_hi), .fest_i(fest_i), .state_o(state_o), .chirp_on(chirp_on),
        .fest_en(fest_en), .lf_acq(lf_acq), .sweep_o(sweep_o), .fsum_o(fsum_o),
        .mp_flag(mp_flag), .filt_o(filt_o)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
        end
    endtask

    // behavioural reference model
    longint m_st, m_f, m_q, m_t, m_mc, m_mf, m_la, m_sw;
    always @(posedge clk) begin
        longint met, a, b, nf, nq, nt, nst, nmc, nmf, nla, nsw, tgt, sum;
        bit above, mvld, qev, msrc, mev;
        if (!rst_n) begin
            m_st = 0; m_f = 0; m_q = 0; m_t = 0; m_mc = 0; m_mf = 0; m_la = 1; m_sw = 0;
        end else begin
            a = longint'(sym_i) * longint'(sym_i) - longint'(sym_q) * longint'(sym_q);
            b = 2 * longint'(sym_i) * longint'(sym_q);
            met = cs_mode ? (a * a - b * b) : a;
            mvld = sym_vld && (cs_mode || frame_sync);
            nf = mvld ? m_f + ((met - m_f) >>> K) : m_f;
            above = m_f > longint'(th1);
            qev = cs_mode ? sym_vld : frame_stb;
            msrc = cs_mode ? timing_sync : frame_sync;
            mev = msrc && qev;
            tgt = cs_mode ? longint'(qual_syms) : 2;
            nst = m_st; nq = 0; nt = 0;
            if (m_st == 0) begin
                nq = !above ? 0 : (qev ? m_q + 1 : m_q);
                if (above && qev && (m_q + 1 >= tgt)) begin nst = 1; nq = 0; end
                else if (m_t == longint'(tmo_lim)) begin nst = 2; nq = 0; end
                else nt = m_t + 1;
            end else if (m_st == 2) begin
                if (above) nst = 1;
            end else begin
                if (m_f < 0) nst = 0;
            end
            nla = above ? 1 : ((m_f < longint'(th2)) ? 0 : m_la);
            if (m_st == 1 || !msrc) begin nmc = 0; nmf = 0; end
            else begin
                nmc = (mev && m_mc != longint'(mp_lim)) ? m_mc + 1 : m_mc;
                nmf = (nmc == longint'(mp_lim)) ? 1 : 0;
            end
            if (m_st == 2) begin
                sum = m_sw + longint'(sweep_step);
                nsw = (sum > longint'(sweep_hi)) ? longint'(sweep_lo) : sum;
            end else nsw = longint'(sweep_lo);
            m_st = nst; m_f = nf; m_q = nq; m_t = nt; m_mc = nmc; m_mf = nmf; m_la = nla; m_sw = nsw;
        end
        #5;
        chk(longint'(state_o) == m_st, "R4 state", longint'(state_o), m_st);
        chk(longint'(filt_o) == m_f, "R1 filtered metric", longint'(filt_o), m_f);
        chk(longint'(lf_acq) == m_la, "R10 gain select", longint'(lf_acq), m_la);
        chk(longint'(sweep_o) == m_sw, "R9 sawtooth", longint'(sweep_o), m_sw);
        chk(longint'(fsum_o) == longint'(fest_i) + m_sw, "R9 sum", longint'(fsum_o), longint'(fest_i) + m_sw);
        chk(fest_en == (m_st != 1), "R11 estimator enable", longint'(fest_en), longint'(m_st != 1));
        chk(chirp_on == (m_st == 2), "R7 sweep flag", longint'(chirp_on), longint'(m_st == 2));
        chk(longint'(mp_flag) == m_mf, "R12 multipath", longint'(mp_flag), m_mf);
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe();
        @(negedge clk) frame_stb = 1'b1;
        @(negedge clk) frame_stb = 1'b0;
    endtask

    task automatic reset_dut();
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
    endtask

    task automatic set_sym(input int i, input int q);
        sym_i = W'(i);
        sym_q = W'(q);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired (all requirements): actual running expected finished");
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        logic signed [MW-1:0] held;
        cyc(3);
        rst_n = 1'b1;
        // R3 reset values
        chk(state_o == 2'd0, "R3 state", state_o, 0);
        chk(filt_o == 0, "R3 filt", filt_o, 0);
        chk(lf_acq && fest_en && !mp_flag && !chirp_on, "R3 flags", {lf_acq, fest_en, mp_flag, chirp_on}, 4'b1100);
        chk(sweep_o == 0, "R3 sweep", sweep_o, 0);

        // framed mode lock: R1, R4, R10, R11
        frame_sync = 1'b1; sym_vld = 1'b1; set_sym(20, 0);
        cyc(1);
        chk(filt_o == 100, "R1 framed metric", filt_o, 100);
        cyc(4);
        strobe(); cyc(3); strobe(); cyc(2);
        chk(state_o == 2'd1, "R4 locked after two frames", state_o, 1);
        chk(fest_en == 1'b0, "R11 estimator off in lock", fest_en, 0);
        chk(lf_acq == 1'b1, "R10 wide gain above th1", lf_acq, 1);

        // R6 exit on negative metric
        set_sym(0, 20);
        cyc(10);
        chk(state_o == 2'd0, "R6 lock lost", state_o, 0);
        chk(lf_acq == 1'b0, "R10 narrow gain below th2", lf_acq, 0);
        chk(fest_en == 1'b1, "R11 estimator on", fest_en, 1);

        // R2 metric ignored without frame lock
        frame_sync = 1'b0; set_sym(20, 0);
        cyc(1);
        held = filt_o;
        cyc(5);
        chk(filt_o == held, "R2 filter held", filt_o, held);

        // R4 interrupted qualification restarts
        frame_sync = 1'b1;
        cyc(8); strobe();
        set_sym(0, 20); cyc(8);
        set_sym(20, 0); cyc(8);
        strobe(); cyc(2);
        chk(state_o == 2'd0, "R4 count restarted", state_o, 0);
        strobe(); cyc(2);
        chk(state_o == 2'd1, "R4 second uninterrupted frame", state_o, 1);

        // R7 timeout into sweep, R9 sawtooth, R8 direct lock
        reset_dut();
        sym_vld = 1'b0; frame_sync = 1'b0; tmo_lim = 20;
        cyc(25);
        chk(state_o == 2'd2, "R7 sweep entered", state_o, 2);
        chk(chirp_on == 1'b1, "R7 sweep flag", chirp_on, 1);
        chk(sweep_o >= -50 && sweep_o <= 50, "R9 sweep in range", sweep_o, 0);
        cyc(6);
        frame_sync = 1'b1; sym_vld = 1'b1; set_sym(20, 0);
        cyc(6);
        chk(state_o == 2'd1, "R8 sweep to lock", state_o, 1);
        chk(sweep_o == -50, "R9 reload outside sweep", sweep_o, -50);
        chk(fsum_o == 50, "R9 estimate sum", fsum_o, 50);

        // R12 framed multipath flag
        reset_dut();
        th1 = 100000; tmo_lim = 1000; mp_lim = 3; sym_vld = 1'b0; frame_sync = 1'b1;
        strobe(); cyc(2); strobe(); cyc(2);
        chk(mp_flag == 1'b0, "R12 below count", mp_flag, 0);
        strobe(); cyc(2);
        chk(mp_flag == 1'b1, "R12 count reached", mp_flag, 1);
        frame_sync = 1'b0; cyc(2);
        chk(mp_flag == 1'b0, "R12 cleared on sync loss", mp_flag, 0);

        // R5 continuous mode qualification
        reset_dut();
        cs_mode = 1'b1; th1 = 200; qual_syms = 5; mp_lim = 1000;
        timing_sync = 1'b1; sym_vld = 1'b1; set_sym(10, 0);
        cyc(1);
        chk(filt_o == 2500, "R1 fourth-power metric", filt_o, 2500);
        cyc(2);
        chk(state_o == 2'd0, "R5 still qualifying", state_o, 0);
        cyc(7);
        chk(state_o == 2'd1, "R5 symbol count met", state_o, 1);

        // R12 continuous multipath flag
        reset_dut();
        th1 = 100000; mp_lim = 10;
        cyc(15);
        chk(mp_flag == 1'b1, "R12 symbol count reached", mp_flag, 1);

        // mixed stimulus against the model
        reset_dut();
        th1 = 150; th2 = -20; tmo_lim = 40; mp_lim = 6; qual_syms = 4;
        sweep_step = 17; sweep_lo = -60; sweep_hi = 70;
        for (int blk = 0; blk < 4; blk++) begin
            cs_mode = blk[0];
            for (int n = 0; n < 100; n++) begin
                @(negedge clk);
                sym_vld     = ($urandom % 4) != 0;
                frame_sync  = ($urandom % 8) != 0;
                timing_sync = ($urandom % 8) != 0;
                frame_stb   = ($urandom % 6) == 0;
                set_sym(int'($urandom % 40) - 20, int'($urandom % 16) - 8);
                fest_i      = SW'(int'($urandom % 200) - 100);
            end
        end
        cyc(2);
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule